// File: doc/BRIEF.md
# External Input Count-Clock Edge Detector

This block converts an external timer input into a one-cycle count-enable pulse for a timer channel. The input is sampled only in system-clock cycles where the channel's operation-clock enable (`op_tick`) is high. An optional digital filter can sit between the sampler and the edge detector. A rising transition of the sampled (or filtered) level produces the pulse. The pulse is therefore delayed by a fixed, known number of operation-clock periods from the pin.

The channel waits in an idle state until a start request arrives. While idle, the sample history is held cleared. A small wrapping up/down counter consumes the pulse, so the bench can see the end-to-end latency at the counter output.

`ext_in` must already be synchronous to `clk`. The first sampling flop is not a metastability synchronizer.

Top module: `ext_edge_counter`

## Requirements
- R1: After reset, `active` is 0, `cnt_pulse` is 0 and `count_val` is 0. A `start_req` sets `active` from the next cycle on. A `stop_req` clears `active` from the next cycle on. When both arrive in the same cycle, stop wins.
- R2: While `active` is 0, `ext_in` is not sampled and `cnt_pulse` stays 0, whatever `ext_in` and `op_tick` do.
- R3: `cnt_pulse` is high for exactly one cycle. It only rises in a cycle where `op_tick` is high, and only on a 0-to-1 change of the detected level. A level that stays high gives a single pulse.
- R4: With `filt_on` = 0, suppose `ext_in` is high when operation tick k samples it and was low at tick k-1. Then `cnt_pulse` is high during tick k+1. This is a delay of 1 to 2 operation-clock periods from the pin.
- R5: With `filt_on` = 1 and the default window of 2, the same input edge gives the pulse during tick k+3. This is a delay of 3 to 4 operation-clock periods.
- R6: With `filt_on` = 1, a level held for fewer consecutive samples than the filter window never changes the detected level. With `filt_on` = 0, a single high sample is counted.
- R7: `count_val` changes in the cycle after a `cnt_pulse` cycle. It steps +1 when `down_sel` = 0 in the pulse cycle, and -1 when `down_sel` = 1. Without a pulse it holds.
- R8: `count_val` wraps modulo 2^16: 0 minus 1 gives 65535, and 65535 plus 1 gives 0.
- R9: Going idle clears the sample history and the detected level to 0. An input already high at the next start is therefore counted once, as a fresh edge. A high level seen before a stop, with the input low at restart, gives no pulse.
- R10: A high or low excursion of `ext_in` that begins and ends between two operation ticks is invisible and is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_tick | input | 1 | Operation-clock enable, one cycle per operation period |
| start_req | input | 1 | Request to enable the channel |
| stop_req | input | 1 | Request to return the channel to idle |
| filt_on | input | 1 | 1 selects the filtered level for edge detection |
| down_sel | input | 1 | Counter direction: 0 up, 1 down |
| ext_in | input | 1 | External count input (synchronous to clk) |
| cnt_pulse | output | 1 | One-cycle count-clock pulse |
| count_val | output | 16 | Up/down counter driven by the pulse |
| active | output | 1 | Channel enabled |

## Verification
The bench measures how many operation ticks separate an input change from the pulse, with and without the filter. A sampler or filter with a stage too many or too few would move the pulse by one tick. The bench drives glitches one sample long and excursions between ticks. A filter that passes short levels, or a sampler that runs on every clock instead of on the tick, would add counts. The bench also restarts the channel with the input held high and with it low. A stop that leaves stale history in place would lose the first count or invent one. Counting down through zero and up through the top checks that the counter wraps and does not saturate.

// File: rtl/eec_pkg.sv
package eec_pkg;

  typedef enum logic {
    CNT_UP   = 1'b0,
    CNT_DOWN = 1'b1
  } cnt_dir_e;

  typedef enum logic {
    RUN_IDLE   = 1'b0,
    RUN_ACTIVE = 1'b1
  } run_state_e;

endpackage

// File: rtl/eec_run_ctrl.sv
module eec_run_ctrl
  import eec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic stop_req,
  output logic active
);

  run_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RUN_IDLE;
    end else if (stop_req) begin
      state_q <= RUN_IDLE;
    end else if (start_req) begin
      state_q <= RUN_ACTIVE;
    end
  end

  assign active = (state_q == RUN_ACTIVE);

endmodule

// File: rtl/eec_edge_sampler.sv
module eec_edge_sampler #(
  parameter int FILT_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic op_tick,
  input  logic filt_on,
  input  logic ext_in,
  output logic det_level,
  output logic hist_level,
  output logic cnt_pulse
);

  localparam int WIN = (FILT_LEN < 2) ? 2 : FILT_LEN;

  // samp_q[0] is the newest operation-clock sample
  logic [WIN-1:0] samp_q;
  logic           steady_q;
  logic           hist_q;
  logic           win_steady;

  function automatic logic window_steady(input logic [WIN-1:0] w);
    return (&w) | ~(|w);
  endfunction

  assign win_steady = window_steady(samp_q);

  genvar gi;
  generate
    for (gi = 0; gi < WIN; gi++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
          samp_q[gi] <= 1'b0;
        end else if (op_tick) begin
          if (gi == 0) begin
            samp_q[gi] <= ext_in;
          end else begin
            samp_q[gi] <= samp_q[(gi == 0) ? 0 : gi-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      steady_q <= 1'b0;
      hist_q   <= 1'b0;
    end else if (op_tick) begin
      if (win_steady) begin
        steady_q <= samp_q[0];
      end
      hist_q <= det_level;
    end
  end

  assign det_level  = filt_on ? steady_q : samp_q[0];
  assign hist_level = hist_q;
  assign cnt_pulse  = op_tick & active & det_level & ~hist_q;

endmodule

// File: rtl/eec_counter.sv
module eec_counter
  import eec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_pulse,
  input  logic             down_sel,
  output logic [CNT_W-1:0] count_val
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] step_count(
    input logic [CNT_W-1:0] cur,
    input cnt_dir_e         dir
  );
    return (dir == CNT_DOWN) ? (cur - ONE) : (cur + ONE);
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_pulse) begin
      cnt_q <= step_count(cnt_q, cnt_dir_e'(down_sel));
    end
  end

  assign count_val = cnt_q;

endmodule

// File: rtl/ext_edge_counter.sv
module ext_edge_counter #(
  parameter int CNT_W    = 16,
  parameter int FILT_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_tick,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             filt_on,
  input  logic             down_sel,
  input  logic             ext_in,
  output logic             cnt_pulse,
  output logic [CNT_W-1:0] count_val,
  output logic             active
);

  // internal events brought out by name for the checker
  logic det_level;
  logic hist_level;

  eec_run_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .stop_req  (stop_req),
    .active    (active)
  );

  eec_edge_sampler #(
    .FILT_LEN (FILT_LEN)
  ) u_samp (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active),
    .op_tick    (op_tick),
    .filt_on    (filt_on),
    .ext_in     (ext_in),
    .det_level  (det_level),
    .hist_level (hist_level),
    .cnt_pulse  (cnt_pulse)
  );

  eec_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_pulse (cnt_pulse),
    .down_sel  (down_sel),
    .count_val (count_val)
  );

endmodule

// File: rtl/ext_edge_counter_chk.sv
module ext_edge_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_tick,
  input logic             start_req,
  input logic             stop_req,
  input logic             down_sel,
  input logic             cnt_pulse,
  input logic [CNT_W-1:0] count_val,
  input logic             active,
  input logic             hist_level
);

  // R1
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !active);

  // R1
  start_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !stop_req) |=> active);

  // R2
  idle_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_pulse |-> active);

  // R3
  pulse_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_pulse |-> op_tick);

  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_pulse |=> !cnt_pulse);

  // R3
  pulse_from_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_pulse |=> (hist_level || !active));

  // R7
  count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_pulse && !down_sel) |=> (count_val == $past(count_val) + CNT_W'(1)));

  // R7
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_pulse && down_sel) |=> (count_val == $past(count_val) - CNT_W'(1)));

  // R7
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_pulse |=> $stable(count_val));

endmodule

bind ext_edge_counter ext_edge_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_tick    (op_tick),
  .start_req  (start_req),
  .stop_req   (stop_req),
  .down_sel   (down_sel),
  .cnt_pulse  (cnt_pulse),
  .count_val  (count_val),
  .active     (active),
  .hist_level (hist_level)
);

// File: tb/ext_edge_counter_test.sv
`timescale 1ns/1ps
module ext_edge_counter_test;

  localparam int FL = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_tick, start_req, stop_req, filt_on, down_sel, ext_in;
  logic        cnt_pulse, active;
  logic [15:0] count_val;

  always #2 clk = ~clk;

  ext_edge_counter #(.CNT_W(16), .FILT_LEN(FL)) uut (
    .clk(clk), .rst_n(rst_n), .op_tick(op_tick), .start_req(start_req),
    .stop_req(stop_req), .filt_on(filt_on), .down_sel(down_sel),
    .ext_in(ext_in), .cnt_pulse(cnt_pulse), .count_val(count_val),
    .active(active)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  bit b_start, b_stop, b_filt, b_down, b_ext;

  // behavioural reference model
  int m_hist_q[$];
  int m_lvl, m_prev, m_act, m_cnt;
  int tick_no, last_pulse_tick;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_hist_q = {};
    for (int i = 0; i < FL; i++) m_hist_q.push_back(0);
    m_lvl  = 0;
    m_prev = 0;
  endtask

  task automatic cyc(input bit tk);
    int det, exp_p, same;
    op_tick = tk; start_req = b_start; stop_req = b_stop;
    filt_on = b_filt; down_sel = b_down; ext_in = b_ext;
    #1;
    det   = b_filt ? m_lvl : m_hist_q[0];
    exp_p = (tk && m_act && det == 1 && m_prev == 0) ? 1 : 0;
    chk(cnt_pulse == exp_p, "R3 pulse", cnt_pulse, exp_p);
    chk(count_val == m_cnt, "R7 count", count_val, m_cnt);
    chk(active == m_act, "R1 active", active, m_act);
    if (tk) begin
      if (cnt_pulse) last_pulse_tick = tick_no;
      tick_no++;
    end
    @(posedge clk);
    if (!m_act) begin
      model_clear();
    end else if (tk) begin
      same = 1;
      foreach (m_hist_q[i]) if (m_hist_q[i] != m_hist_q[0]) same = 0;
      m_prev = det;
      if (same) m_lvl = m_hist_q[0];
      m_hist_q.push_front(b_ext);
      void'(m_hist_q.pop_back());
    end
    if (exp_p) m_cnt = b_down ? ((m_cnt + 65535) % 65536) : ((m_cnt + 1) % 65536);
    if (b_stop) m_act = 0;
    else if (b_start) m_act = 1;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1); cyc(0); cyc(0);
    end
  endtask

  task automatic glitch();
    b_ext = 1; cyc(1); b_ext = 0; cyc(0); cyc(0);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int e;
    b_start = 0; b_stop = 0; b_filt = 0; b_down = 0; b_ext = 0;
    op_tick = 0; start_req = 0; stop_req = 0; filt_on = 0; down_sel = 0; ext_in = 0;
    m_act = 0; m_cnt = 0; tick_no = 0; last_pulse_tick = -1;
    model_clear();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(active == 0, "R1 reset active", active, 0);
    chk(cnt_pulse == 0, "R1 reset pulse", cnt_pulse, 0);
    chk(count_val == 0, "R1 reset count", count_val, 0);
    rst_n = 1;

    // R2 idle: input activity ignored
    for (int i = 0; i < 4; i++) begin
      b_ext = 1; ticks(2); b_ext = 0; ticks(2);
    end
    chk(count_val == 0, "R2 idle count", count_val, 0);

    b_start = 1; cyc(0); b_start = 0;
    chk(active == 1, "R1 start", active, 1);
    ticks(3);

    // R4 unfiltered latency
    e = tick_no; b_ext = 1; ticks(4);
    chk(last_pulse_tick == e + 1, "R4 latency", last_pulse_tick, e + 1);
    chk(count_val == 1, "R7 up", count_val, 1);

    // R3 held level gives one pulse
    ticks(6);
    chk(count_val == 1, "R3 held", count_val, 1);

    // R7 down
    b_down = 1; b_ext = 0; ticks(3); b_ext = 1; ticks(3);
    chk(count_val == 0, "R7 down", count_val, 0);

    // R8 wrap
    b_ext = 0; ticks(3); b_ext = 1; ticks(3);
    chk(count_val == 65535, "R8 under", count_val, 65535);
    b_down = 0; b_ext = 0; ticks(3); b_ext = 1; ticks(3);
    chk(count_val == 0, "R8 over", count_val, 0);

    // R5 filtered latency
    b_filt = 1; b_ext = 0; ticks(5);
    e = tick_no; b_ext = 1; ticks(6);
    chk(last_pulse_tick == e + FL + 1, "R5 latency", last_pulse_tick, e + FL + 1);
    chk(count_val == 1, "R5 count", count_val, 1);

    // R6 glitch rejected with filter, counted without
    b_ext = 0; ticks(5); glitch(); ticks(5);
    chk(count_val == 1, "R6 filtered", count_val, 1);
    b_filt = 0; ticks(3); glitch(); ticks(3);
    chk(count_val == 2, "R6 unfiltered", count_val, 2);

    // R10 excursions between ticks are invisible
    for (int i = 0; i < 4; i++) begin
      b_ext = 0; cyc(1); b_ext = 1; cyc(0); b_ext = 0; cyc(0);
    end
    ticks(3);
    chk(count_val == 2, "R10 between ticks", count_val, 2);

    // R9 restart behaviour
    b_ext = 1; ticks(3);
    chk(count_val == 3, "R9 pre-stop", count_val, 3);
    b_stop = 1; cyc(0); b_stop = 0;
    chk(active == 0, "R1 stop", active, 0);
    ticks(2);
    b_start = 1; cyc(0); b_start = 0; ticks(3);
    chk(count_val == 4, "R9 high at start", count_val, 4);
    b_stop = 1; cyc(0); b_stop = 0; b_ext = 0; ticks(2);
    b_start = 1; cyc(0); b_start = 0; ticks(4);
    chk(count_val == 4, "R9 low at start", count_val, 4);

    // R1 stop wins over start
    b_stop = 1; b_start = 1; cyc(0); b_stop = 0; b_start = 0;
    chk(active == 0, "R1 stop priority", active, 0);
    ticks(2);

    report();
  end

endmodule